// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a synchronous host and a byte-wide asynchronous static RAM. The host hands over one request at a time on a valid/ready port. Each request is a read or a write of one byte at a 19-bit address. The block turns it into a strobe sequence on the memory pins: chip select, write enable and output enable, all active low, plus an address bus and a split data path. The split data path carries outgoing data, an output-enable for the pad, and incoming data. Every strobe width and settle interval is a parameter counted in clock cycles, so the memory's nanosecond rules can be met at the chosen clock.

A write holds output enable high. It pulls select and write enable low together and drives the data for the whole pulse. A read pulls select and output enable low for a fixed strobe time and then captures the incoming byte on the edge that ends the strobe. The captured byte goes back to the host with a one-cycle response pulse. After every access all strobes stay high for a turnaround interval, so the memory's outputs release before anything else drives the shared wires.

A retention mode deselects the memory while a sleep request is held. When the request drops, the block waits a programmable recovery count before it accepts the next access. Requests that arrive during sleep or recovery wait on the port.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable are high, the data pad is not driven, `rsp_valid` is low and `req_ready` is high.
- R2: A write holds chip select and write enable low together for exactly WR_PULSE cycles. Output enable stays high throughout, and the request's data is driven on `mem_dq_out` with `mem_dq_oe` high for the whole pulse.
- R3: `mem_dq_oe` only rises after output enable has been high for at least TURN_CYC consecutive cycles. It is never high while output enable is low.
- R4: A read holds chip select and output enable low with write enable high for RD_STROBE cycles. The byte on `mem_dq_in` is captured on the edge that ends the strobe. It is presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle, on the sixth falling edge after acceptance at default parameters.
- R5: After each access every strobe stays high for TURN_CYC cycles. `req_ready` is low from acceptance until that interval ends, which is WR_PULSE+TURN_CYC cycles for a write and RD_STROBE+TURN_CYC cycles for a read.
- R6: A request is taken only on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is never high while chip select is low.
- R7: While `sleep_req` is high and no access is in progress, chip select is held high, `req_ready` is low, and a pending request produces no strobe activity.
- R8: After `sleep_req` falls, `req_ready` stays low for WAKE_CYC cycles. A request stalled through sleep is then carried out.
- R9: The address stays stable during every cycle in which chip select is low.
- R10: While chip select is high, write enable and output enable are high and the pad is not driven. Write enable and output enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Hold high to enter data-retention deselect |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The embedded properties check on every cycle the static strobe rules: the standby encoding, no overlap of write and output enable, and address stability under select. They also check the counted windows: write-enable width, the output-high interval before the pad is driven, the single-cycle response and deselect during sleep. Only the bench scenarios can show the data itself: that bytes written land at the right address, and that reads return them after the full access delay, which the memory model enforces by presenting garbage until the strobe has lasted long enough. Only the scenarios show the cycle counts seen from the host, the stalling of a request through sleep and the exact recovery length before it completes.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_TURN,
        ST_SLEEP,
        ST_WAKE
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } bus_ctl_t;

    localparam bus_ctl_t BUS_QUIET = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // Pin levels held during each state; registered by the sequencer.
    function automatic bus_ctl_t strobes_for(ctl_state_e s);
        bus_ctl_t b;
        b = BUS_QUIET;
        case (s)
            ST_WRITE: b = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_READ:  b = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            default:  b = BUS_QUIET;
        endcase
        return b;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);  // R5
endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
    import sramc_pkg::*;
#(
    parameter int WR_PULSE   = 4,
    parameter int RD_STROBE  = 5,
    parameter int TURN_CYC   = 2,
    parameter int DATA_SETUP = 3,
    parameter int WAKE_CYC   = 500000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sleep_req,
    input  logic     req_valid,
    input  logic     req_write,
    output logic     req_ready,
    output logic     accept,
    output logic     capture,
    output bus_ctl_t bus
);
    localparam int unsigned CNT_MAX = max2(max2(WR_PULSE, RD_STROBE), max2(TURN_CYC, WAKE_CYC));
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam int RUN_W = $clog2(max2(max2(WR_PULSE, TURN_CYC), DATA_SETUP) + 2);

    ctl_state_e       st_q, st_d;
    logic             tm_load, tm_zero;
    logic [CNT_W-1:0] tm_val;
    bus_ctl_t         bus_q;

    sramc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .zero     (tm_zero)
    );

    assign req_ready = (st_q == ST_IDLE) && !sleep_req;
    assign accept    = req_ready && req_valid;

    always_comb begin
        st_d    = st_q;
        tm_load = 1'b0;
        tm_val  = '0;
        capture = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (sleep_req) begin
                    st_d = ST_SLEEP;
                end else if (req_valid) begin
                    tm_load = 1'b1;
                    if (req_write) begin
                        st_d   = ST_WRITE;
                        tm_val = CNT_W'(WR_PULSE - 1);
                    end else begin
                        st_d   = ST_READ;
                        tm_val = CNT_W'(RD_STROBE - 1);
                    end
                end
            end
            ST_WRITE: begin
                if (tm_zero) begin
                    st_d    = ST_TURN;
                    tm_load = 1'b1;
                    tm_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_READ: begin
                if (tm_zero) begin
                    capture = 1'b1;
                    st_d    = ST_TURN;
                    tm_load = 1'b1;
                    tm_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_TURN: begin
                if (tm_zero) st_d = ST_IDLE;
            end
            ST_SLEEP: begin
                if (!sleep_req) begin
                    st_d    = ST_WAKE;
                    tm_load = 1'b1;
                    tm_val  = CNT_W'(WAKE_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (tm_zero) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Strobes come from flops so the memory never sees a decode glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            bus_q <= BUS_QUIET;
        end else begin
            st_q  <= st_d;
            bus_q <= strobes_for(st_d);
        end
    end

    assign bus = bus_q;

    // Run-length trackers for the timing properties below.
    logic [RUN_W-1:0] we_low_run, oe_high_run, data_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_run  <= '0;
            oe_high_run <= RUN_W'(TURN_CYC);
            data_run    <= '0;
        end else begin
            we_low_run  <= !bus_q.we_n ? ((we_low_run == '1) ? we_low_run : we_low_run + 1'b1) : '0;
            oe_high_run <= bus_q.oe_n ? ((oe_high_run == '1) ? oe_high_run : oe_high_run + 1'b1) : '0;
            data_run    <= bus_q.dq_oe ? ((data_run == '1) ? data_run : data_run + 1'b1) : '0;
        end
    end

    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_q.we_n) |-> (we_low_run == RUN_W'(WR_PULSE)));  // R2
    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_q.we_n) |-> (data_run >= RUN_W'(DATA_SETUP)));  // R2
    AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !bus_q.we_n |-> bus_q.oe_n);  // R10
    AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_q.dq_oe) |-> (oe_high_run >= RUN_W'(TURN_CYC)));  // R3
    AST_NO_DRIVE_UNDER_OE: assert property (@(posedge clk) disable iff (rst)
        bus_q.dq_oe |-> bus_q.oe_n);  // R3
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_q.cs_n |-> (bus_q.we_n && bus_q.oe_n && !bus_q.dq_oe));  // R10
    AST_SLEEP_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SLEEP || st_q == ST_WAKE) |-> (bus_q.cs_n && !req_ready));  // R7
endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= mem_dq_in;
            rsp_q <= capture;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_valid  = rsp_q;
    assign rsp_rdata  = rdata_q;

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_q |=> !rsp_q);  // R4
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int WR_PULSE   = 4,
    parameter int RD_STROBE  = 5,
    parameter int TURN_CYC   = 2,
    parameter int DATA_SETUP = 3,
    parameter int WAKE_CYC   = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic     accept, capture;
    bus_ctl_t bus;

    sramc_fsm #(
        .WR_PULSE   (WR_PULSE),
        .RD_STROBE  (RD_STROBE),
        .TURN_CYC   (TURN_CYC),
        .DATA_SETUP (DATA_SETUP),
        .WAKE_CYC   (WAKE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .bus       (bus)
    );

    sramc_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    assign mem_cs_n  = bus.cs_n;
    assign mem_we_n  = bus.we_n;
    assign mem_oe_n  = bus.oe_n;
    assign mem_dq_oe = bus.dq_oe;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));  // R9
    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_cs_n);  // R6
endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
    localparam int WRP = 4, RDS = 5, TRN = 2, WAKE = 20;

    logic        clk = 1'b0, rst = 1'b1;
    logic        sleep_req = 1'b0, req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rsp_rdata, mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;
    logic [18:0] mem_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_async_ctrl #(.WR_PULSE(WRP), .RD_STROBE(RDS), .TURN_CYC(TRN),
                      .DATA_SETUP(3), .WAKE_CYC(WAKE)) u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in));

    // Memory model and bus monitor, evaluated between clock edges.
    logic [7:0] memarr [logic [18:0]];
    int rd_cnt = 0, we_run = 0, we_len = 0, oe_run = 0, oe_len = 0;
    int oe_hi_run = 100, drive_gap = 100, we_falls = 0;
    int oe_in_write = 0, standby_bad = 0, addr_bad = 0;
    logic prev_oe = 0, prev_cs = 1, prev_we = 1;
    logic [18:0] prev_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cs_n && !mem_we_n && mem_dq_oe) memarr[mem_addr] = mem_dq_out;
            rd_cnt = (!mem_cs_n && !mem_oe_n) ? rd_cnt + 1 : 0;
            mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n && rd_cnt >= RDS) ? memarr[mem_addr] : 8'hEE;
            if (!mem_we_n) we_run++; else if (we_run != 0) begin we_len = we_run; we_run = 0; end
            if (!mem_oe_n) oe_run++; else if (oe_run != 0) begin oe_len = oe_run; oe_run = 0; end
            if (mem_dq_oe && !prev_oe) drive_gap = oe_hi_run;
            oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
            if (!mem_we_n && prev_we) we_falls++;
            if (!mem_we_n && !mem_oe_n) oe_in_write++;
            if (mem_cs_n && (!mem_we_n || !mem_oe_n || mem_dq_oe)) standby_bad++;
            if (!mem_cs_n && !prev_cs && mem_addr != prev_addr) addr_bad++;
            prev_oe = mem_dq_oe; prev_cs = mem_cs_n; prev_we = mem_we_n; prev_addr = mem_addr;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Presents a request and returns at the first falling edge after it was taken.
    task automatic issue(bit wr, logic [18:0] a, logic [7:0] d);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset();
        check({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b1110, "R1 strobes",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        check(req_ready == 1, "R1 ready", req_ready, 1);
        check(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_write(logic [18:0] a, logic [7:0] d);
        int low = 0, ow = oe_in_write;
        issue(1, a, d);
        while (!req_ready && low < 50) begin low++; @(negedge clk); end
        check(low == WRP + TRN, "R5 write busy", low, WRP + TRN);
        check(we_len == WRP, "R2 we width", we_len, WRP);
        check(oe_in_write == ow, "R2 oe high in write", oe_in_write - ow, 0);
        check(memarr[a] == d, "R2 stored byte", memarr[a], d);
    endtask

    task automatic t_read(logic [18:0] a, logic [7:0] exp);
        int low = 0, hit = 0, pulses = 0;
        logic [7:0] got = 8'h00;
        issue(0, a, 8'h00);
        for (int n = 1; n <= 12; n++) begin
            if (rsp_valid) begin pulses++; if (hit == 0) begin hit = n; got = rsp_rdata; end end
            if (!req_ready && low == n - 1) low = n;
            @(negedge clk);
        end
        check(hit == RDS + 1, "R4 response edge", hit, RDS + 1);
        check(got == exp, "R4 read data", got, exp);
        check(pulses == 1, "R4 single pulse", pulses, 1);
        check(oe_len == RDS, "R4 strobe width", oe_len, RDS);
        check(low == RDS + TRN, "R5 read busy", low, RDS + TRN);
    endtask

    task automatic t_turnaround();
        issue(0, 19'h00123, 8'h00);
        issue(1, 19'h00124, 8'h5C);
        repeat (10) @(negedge clk);
        check(drive_gap >= TRN, "R3 oe high before drive", drive_gap, TRN);
        check(drive_gap == RDS - RDS + TRN + 1, "R6 back-to-back accept", drive_gap, TRN + 1);
        check(memarr[19'h00124] == 8'h5C, "R3 write after read", memarr[19'h00124], 8'h5C);
    endtask

    task automatic t_sleep();
        int bad = 0, wake = 0, wf;
        sleep_req = 1;
        req_valid = 1; req_write = 1; req_addr = 19'h0BEEF; req_wdata = 8'h77;
        wf = we_falls;
        repeat (8) begin
            @(negedge clk);
            if (req_ready || !mem_cs_n) bad++;
        end
        check(bad == 0, "R7 deselected and stalled", bad, 0);
        check(we_falls == wf, "R7 no strobe in sleep", we_falls - wf, 0);
        check(memarr[19'h0BEEF] == 8'h11, "R7 memory untouched", memarr[19'h0BEEF], 8'h11);
        sleep_req = 0;
        @(negedge clk);
        while (!req_ready && wake < 100) begin wake++; @(negedge clk); end
        check(wake == WAKE, "R8 recovery length", wake, WAKE);
        @(negedge clk);
        req_valid = 0;
        repeat (10) @(negedge clk);
        check(memarr[19'h0BEEF] == 8'h77, "R8 stalled write done", memarr[19'h0BEEF], 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_write(19'h00000, 8'hA5);
        t_write(19'h7FFFF, 8'h3C);
        t_write(19'h2AAAA, 8'hFF);
        t_read(19'h7FFFF, 8'h3C);
        t_read(19'h00000, 8'hA5);
        t_read(19'h2AAAA, 8'hFF);
        t_turnaround();
        t_write(19'h0BEEF, 8'h11);
        t_sleep();
        t_read(19'h0BEEF, 8'h77);
        check(addr_bad == 0, "R9 address stable", addr_bad, 0);
        check(standby_bad == 0, "R10 standby encoding", standby_bad, 0);
        check(oe_in_write == 0, "R10 we/oe overlap", oe_in_write, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule